// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block contains two pulse-width modulation channels that run side by side on one system clock. Each channel has a 16-bit counter, a period register and a duty-compare register. The counter advances only on a clock-enable pulse from that channel's own prescaler. The prescaler divides the system clock by 4 or by 12, and each channel picks its ratio with its own bit. The counter counts from zero up to the period value and then wraps. At the wrap it raises a one-cycle boundary strobe. The raw output is high while the count is below the duty value.

Software configures the block through a small write-only register port. Each channel can take a new duty value in one of two ways. In immediate mode the new value applies on the next clock. In synchronized mode it waits in a shadow register until the next period boundary, so a period is never cut short or stretched by a change in the middle of it. The raw outputs and strobes are meant for a separate output stage, which handles pin pairing and dead time.

Top module: `pwm2_gen`

## Requirements
- R1: After reset, every counter, period, duty, prescale bit and update-mode bit is 0 and both PWM outputs are low. A channel's boundary strobe then repeats every 4 system cycles.
- R2: When a channel's prescale bit is 0, its counter advances once every 4 system cycles. A period of value P therefore lasts (P+1)*4 system cycles from one strobe to the next.
- R3: When a channel's prescale bit is 1, its counter advances once every 12 system cycles, so a period lasts (P+1)*12 system cycles.
- R4: The prescale bit of one channel has no effect on the timing of the other channel.
- R5: The counter runs from 0 to P and then returns to 0. On each return the boundary strobe is high for exactly one system cycle, aligned with the first cycle of the new period.
- R6: The output is high while the count is below the active duty D. Over one period it is high for min(D, P+1) counter steps. D=0 gives a constant low output, and D>P gives a constant high output.
- R7: In immediate mode (update-mode bit 0), a written duty value becomes active on the clock edge that accepts the write, which can be in the middle of a period.
- R8: In synchronized mode (update-mode bit 1), a written duty value is held in a shadow register. It becomes active only at the next period boundary, so the period in progress keeps its old duty.
- R9: The period and duty of each channel are set independently. Writing one channel's period or duty leaves the other channel's output unchanged.
- R10: Register map on wr_addr. Address 0 is the control register: bit 0 is the channel 0 prescale bit, bit 1 the channel 1 prescale bit, bit 2 the channel 0 update mode and bit 3 the channel 1 update mode. Address 1 is the channel 0 period, 2 the channel 0 duty, 3 the channel 1 period and 4 the channel 1 duty. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pwm_out | output | 2 | Raw PWM output, one bit per channel |
| period_strobe | output | 2 | One-cycle period-boundary strobe, one bit per channel |

## Verification
The assertions assume that wr_en is never unknown after reset. They also assume that the duty-active register changes only through a write in immediate mode or a shadow copy at a wrap, so any change seen while the previous cycle was in synchronized mode must line up with a boundary strobe. The stimulus makes every configuration change, including period, prescale and mode changes, before it waits for a boundary. It then measures only whole periods that start after that boundary, because a period in progress when the period register is lowered is shortened on purpose. Random periods stay between 1 and 30 and random duties between 0 and P+2, so the constant-high case comes up without long runs.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  localparam int CTRL_ADDR = 0;

  function automatic int period_addr(input int ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int duty_addr(input int ch);
    return 2 + 2 * ch;
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_hi,
  output logic tick
);
  localparam int W = $clog2(DIV_HI);
  localparam logic [W-1:0] LIM_LO = W'(DIV_LO - 1);
  localparam logic [W-1:0] LIM_HI = W'(DIV_HI - 1);

  logic [W-1:0] div_cnt;
  logic [W-1:0] limit;

  assign limit = sel_hi ? LIM_HI : LIM_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt >= limit) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end

  // R2/R3: the enable is a single-cycle pulse, never two in a row
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] presc_sel,
  output logic [NUM_CH-1:0] sync_mode,
  output logic [NUM_CH-1:0] per_we,
  output logic [NUM_CH-1:0] duty_we
);
  localparam int CTRL_W = 2 * NUM_CH;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(pwm2_pkg::CTRL_ADDR)) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  assign presc_sel = ctrl_q[NUM_CH-1:0];
  assign sync_mode = ctrl_q[CTRL_W-1:NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign per_we[c]  = wr_en && (wr_addr == ADDR_W'(pwm2_pkg::period_addr(c)));
    assign duty_we[c] = wr_en && (wr_addr == ADDR_W'(pwm2_pkg::duty_addr(c)));
  end

  // R10: a write reaches at most one channel register
  p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({per_we, duty_we}));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sync_mode,
  input  logic             per_we,
  input  logic             duty_we,
  input  logic [CNT_W-1:0] wdata,
  output logic             pwm_o,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] duty_q, duty_n;
  logic             wrap;

  always_comb begin
    wrap  = tick && (cnt_q >= period_q);
    cnt_n = cnt_q;
    if (tick) cnt_n = wrap ? '0 : cnt_q + 1'b1;
    duty_n = duty_q;
    if (duty_we && !sync_mode)   duty_n = wdata;
    else if (wrap && sync_mode)  duty_n = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= '0;
      shadow_q <= '0;
      duty_q   <= '0;
      pwm_o    <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      duty_q   <= duty_n;
      pwm_o    <= (cnt_n < duty_n);
      strobe_o <= wrap;
      if (per_we)  period_q <= wdata;
      if (duty_we) shadow_q <= wdata;
    end
  end

  // R2: the count moves only after an enable pulse
  p_count_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(cnt_q));

  // R5: the strobe is one cycle wide and marks count zero
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
  p_strobe_zero_r5: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (cnt_q == '0));

  // R6: a zero duty keeps the output low
  p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |-> !pwm_o);

  // R8: in synchronized mode the active duty moves only at a boundary
  p_sync_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(duty_q) && $past(sync_mode)) |-> strobe_o);

endmodule

// File: rtl/pwm2_gen.sv
module pwm2_gen #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] period_strobe
);
  logic [NUM_CH-1:0] presc_sel;
  logic [NUM_CH-1:0] sync_mode;
  logic [NUM_CH-1:0] per_we;
  logic [NUM_CH-1:0] duty_we;
  logic [NUM_CH-1:0] tick;

  pwm_regs #(
    .NUM_CH(NUM_CH),
    .DATA_W(CNT_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .presc_sel(presc_sel),
    .sync_mode(sync_mode),
    .per_we   (per_we),
    .duty_we  (duty_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_prescale #(
      .DIV_LO(DIV_LO),
      .DIV_HI(DIV_HI)
    ) u_presc (
      .clk   (clk),
      .rst   (rst),
      .sel_hi(presc_sel[c]),
      .tick  (tick[c])
    );

    pwm_channel #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick[c]),
      .sync_mode(sync_mode[c]),
      .per_we   (per_we[c]),
      .duty_we  (duty_we[c]),
      .wdata    (wr_data),
      .pwm_o    (pwm_out[c]),
      .strobe_o (period_strobe[c])
    );
  end

  // R1: outputs are low in the cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    $past(rst) |-> (pwm_out == '0));

endmodule

// File: tb/test_pwm2_gen.sv
module test_pwm2_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  pwm_out;
  logic [1:0]  period_strobe;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwm2_gen i_pwm2_gen (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pwm_out      (pwm_out),
    .period_strobe(period_strobe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_stb(input int ch);
    do @(negedge clk); while (period_strobe[ch] !== 1'b1);
  endtask

  task automatic measure(input int ch, output int len, output int hi);
    wait_stb(ch);
    len = 1;
    hi  = int'(pwm_out[ch]);
    forever begin
      @(negedge clk);
      if (period_strobe[ch]) break;
      len++;
      hi += int'(pwm_out[ch]);
    end
  endtask

  // one window with a register write issued two cycles after its start
  task automatic window_write(input int ch, input int a, input int d,
                              output int len, output int hi);
    wait_stb(ch);
    len = 1;
    hi  = int'(pwm_out[ch]);
    forever begin
      @(negedge clk);
      if (len == 2) begin
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
      end else begin
        wr_en = 1'b0;
      end
      if (period_strobe[ch]) break;
      len++;
      hi += int'(pwm_out[ch]);
    end
    wr_en = 1'b0;
  endtask

  function automatic int exp_hi(input int d, input int p, input int div);
    return ((d > p + 1) ? p + 1 : d) * div;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len, hi, len1, hi1, hi_any;
    void'($urandom(32'd2024));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: outputs low after reset, period 0 boundary every 4 cycles
    hi_any = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      hi_any += int'(pwm_out[0]) + int'(pwm_out[1]);
    end
    chk("R1 outputs low after reset", hi_any, 0);
    measure(0, len, hi);
    chk("R1 reset period length ch0", len, 4);
    measure(1, len, hi);
    chk("R1 reset period length ch1", len, 4);

    // R2 / R6: prescale 4, period 7, duty 3
    wr(1, 7); wr(2, 3);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R2 length div4", len, 32);
    chk("R6 high time div4", hi, 12);

    // R3: channel 0 on divide-by-12
    wr(0, 1);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R3 length div12", len, 96);
    chk("R6 high time div12", hi, 36);

    // R4 / R9: channel 1 on divide-by-4 with its own period and duty (D>P)
    wr(3, 4); wr(4, 5);
    measure(1, len1, hi1);
    measure(1, len1, hi1);
    chk("R4 ch1 length unaffected by ch0 prescale", len1, 20);
    chk("R6 duty above period is constant high", hi1, 20);
    measure(0, len, hi);
    chk("R9 ch0 length unchanged by ch1 writes", len, 96);
    chk("R9 ch0 high unchanged by ch1 writes", hi, 36);
    wr(0, 2);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R4 ch0 length unaffected by ch1 prescale", len, 32);
    measure(1, len1, hi1);
    measure(1, len1, hi1);
    chk("R3 ch1 length div12", len1, 60);
    wr(0, 0);

    // R6: zero duty
    wr(2, 0);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R6 zero duty constant low", hi, 0);
    chk("R5 length with zero duty", len, 32);

    // R7: immediate mode, duty raised mid-period
    wr(1, 9); wr(2, 2);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R7 baseline high", hi, 8);
    window_write(0, 2, 7, len, hi);
    chk("R7 immediate update inside window", hi, 28);
    chk("R5 window length unaffected by duty write", len, 40);

    // R8: synchronized mode, duty raised mid-period
    wr(2, 2);
    wr(0, 4);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R8 baseline high", hi, 8);
    window_write(0, 2, 7, len, hi);
    chk("R8 current period keeps old duty", hi, 8);
    measure(0, len, hi);
    chk("R8 new duty at next boundary", hi, 28);

    // R10: writes to unused addresses have no effect
    wr(0, 0); wr(1, 5); wr(2, 3); wr(3, 6); wr(4, 2);
    wr(5, 0); wr(6, 16'hffff); wr(7, 0);
    measure(0, len, hi);
    measure(0, len, hi);
    chk("R10 ch0 length after unused writes", len, 24);
    chk("R10 ch0 high after unused writes", hi, 12);
    measure(1, len1, hi1);
    chk("R10 ch1 length after unused writes", len1, 28);
    chk("R10 ch1 high after unused writes", hi1, 8);

    // R2 R3 R6: constrained random configurations
    for (int it = 0; it < 16; it++) begin
      int p0, p1, d0, d1, s0, s1;
      p0 = $urandom_range(1, 30); p1 = $urandom_range(1, 30);
      d0 = $urandom_range(0, p0 + 2); d1 = $urandom_range(0, p1 + 2);
      s0 = $urandom_range(0, 1); s1 = $urandom_range(0, 1);
      wr(0, s0 | (s1 << 1));
      wr(1, p0); wr(2, d0); wr(3, p1); wr(4, d1);
      measure(0, len, hi);
      chk("R2 random ch0 length", len, (p0 + 1) * (s0 ? 12 : 4));
      chk("R6 random ch0 high", hi, exp_hi(d0, p0, s0 ? 12 : 4));
      measure(1, len1, hi1);
      chk("R3 random ch1 length", len1, (p1 + 1) * (s1 ? 12 : 4));
      chk("R6 random ch1 high", hi1, exp_hi(d1, p1, s1 ? 12 : 4));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule